// File: doc/BRIEF.md
# Fetch-Stage Next Program Counter Selector

This block holds the fetch-stage program counter of a 32-bit pipelined processor and chooses, every cycle, which address it fetches next. The candidates are the sequential address, a PC-relative branch target, an absolute jump target spliced from the upper PC bits and a 26-bit instruction field, a register-supplied jump address, and three fixed vectors: one for reset, one for an illegal opcode and one for an interrupt. External control logic decides which candidate wins and presents a 3-bit select code. Instruction memory, decode and the branch-condition decision live elsewhere.

The PC and its sequential successor are both registered. The fetch stage uses `pc` to address instruction memory and passes it to decode with the fetched word. `pc_plus4` gives the return-address logic the sequential address without an adder of its own. A stall input freezes both registers. A synchronous reset forces the reset vector whatever the other inputs are.

Top module: `pc_steer`

## Requirements
- R1: While `rst` is high at a rising edge, `pc` becomes 0x80000000 and `pc_plus4` becomes 0x80000004 after that edge, whatever `sel`, `stall`, `instr_field` and `reg_jump` are.
- R2: With select code 0, the next `pc` is the current `pc` plus 4.
- R3: With select code 1, the next `pc` is the current `pc` plus 4 plus four times `instr_field[15:0]` read as a signed 16-bit value.
- R4: With select code 2, the next `pc` is {current `pc[31:28]`, `instr_field[25:0]`, 2'b00}.
- R5: With select code 3, the next `pc` is `reg_jump` with its two low bits forced to zero.
- R6: With select code 4, the next `pc` is 0x80000040 (illegal-opcode vector).
- R7: With select code 5, the next `pc` is 0x80000080 (interrupt vector).
- R8: With select code 6, the next `pc` is 0x80000000 (reset vector).
- R9: Select code 7 is a spare code and behaves exactly like code 0.
- R10: While `stall` is high and `rst` is low, `pc` and `pc_plus4` keep their values and `sel`, `instr_field` and `reg_jump` have no effect. Reset takes priority over stall.
- R11: At every cycle after reset, `pc_plus4` equals `pc` plus 4, modulo 2^32.
- R12: Address arithmetic wraps modulo 2^32. 0xFFFFFFFC plus 4 gives 0, and a branch offset that carries past bit 31 is dropped.
- R13: `pc` bits 1:0 are zero at every cycle after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| stall | input | 1 | Holds the PC registers when high |
| sel | input | 3 | Next-address source code (0..7, see R2 to R9) |
| instr_field | input | 26 | Low 26 bits of the current instruction: jump index, with the branch immediate in bits 15:0 |
| reg_jump | input | 32 | Jump address read from the register file |
| pc | output | 32 | Registered program counter |
| pc_plus4 | output | 32 | Registered sequential successor of `pc` |

## Verification
The assertions assume that `rst` is asserted for at least one edge before any check applies, and that `sel`, `stall`, `instr_field` and `reg_jump` are stable around each rising edge. They make no assumption about the alignment of `reg_jump` or the value of `sel`. The bench therefore holds reset high from time zero and changes every input only just after a rising edge. It also drives deliberately misaligned register-jump values and the spare select code. Each check is sampled one time unit after the edge that loads the result.

// File: rtl/pcsteer_pkg.sv
package pcsteer_pkg;

  localparam int SEL_W = 3;

  typedef enum logic [SEL_W-1:0] {
    SRC_SEQ   = 3'd0,
    SRC_BRCH  = 3'd1,
    SRC_JABS  = 3'd2,
    SRC_JREG  = 3'd3,
    SRC_ILL   = 3'd4,
    SRC_IRQ   = 3'd5,
    SRC_RST   = 3'd6,
    SRC_SPARE = 3'd7
  } pc_src_e;

  typedef struct packed {
    logic [31:0] seq;
    logic [31:0] brch;
    logic [31:0] jabs;
    logic [31:0] jreg;
  } pc_cand_t;

endpackage

// File: rtl/pcsteer_targets.sv
module pcsteer_targets #(
  parameter int XLEN    = 32,
  parameter int FIELD_W = 26,
  parameter int IMM_W   = 16
) (
  input  logic [XLEN-1:0]    cur_pc,
  input  logic [FIELD_W-1:0] field,
  input  logic [XLEN-1:0]    rj_val,
  output logic [XLEN-1:0]    seq_addr,
  output logic [XLEN-1:0]    brch_addr,
  output logic [XLEN-1:0]    jabs_addr,
  output logic [XLEN-1:0]    jreg_addr
);
  localparam int KEEP_W = XLEN - FIELD_W - 2;
  localparam int EXT_W  = XLEN - IMM_W - 2;
  localparam logic [XLEN-1:0] WORD = XLEN'(4);
  localparam logic [XLEN-1:0] ALIGN_MASK = ~XLEN'(3);

  logic [IMM_W-1:0] imm;
  logic [XLEN-1:0]  offs;

  always_comb begin
    imm       = field[IMM_W-1:0];
    offs      = {{EXT_W{imm[IMM_W-1]}}, imm, 2'b00};
    seq_addr  = cur_pc + WORD;
    brch_addr = seq_addr + offs;
    jabs_addr = {cur_pc[XLEN-1 -: KEEP_W], field, 2'b00};
    jreg_addr = rj_val & ALIGN_MASK;
  end
endmodule

// File: rtl/pcsteer_mux.sv
module pcsteer_mux
  import pcsteer_pkg::*;
#(
  parameter int XLEN = 32,
  parameter logic [XLEN-1:0] VEC_RESET = 32'h8000_0000,
  parameter logic [XLEN-1:0] VEC_ILL   = 32'h8000_0040,
  parameter logic [XLEN-1:0] VEC_IRQ   = 32'h8000_0080
) (
  input  logic [SEL_W-1:0] code,
  input  logic [XLEN-1:0]  seq_addr,
  input  logic [XLEN-1:0]  brch_addr,
  input  logic [XLEN-1:0]  jabs_addr,
  input  logic [XLEN-1:0]  jreg_addr,
  output logic [XLEN-1:0]  next_addr
);
  pc_src_e src;

  always_comb begin
    src = pc_src_e'(code);
    unique case (src)
      SRC_SEQ:   next_addr = seq_addr;
      SRC_BRCH:  next_addr = brch_addr;
      SRC_JABS:  next_addr = jabs_addr;
      SRC_JREG:  next_addr = jreg_addr;
      SRC_ILL:   next_addr = VEC_ILL;
      SRC_IRQ:   next_addr = VEC_IRQ;
      SRC_RST:   next_addr = VEC_RESET;
      SRC_SPARE: next_addr = seq_addr;
      default:   next_addr = seq_addr;
    endcase
  end
endmodule

// File: rtl/pcsteer_reg.sv
module pcsteer_reg #(
  parameter int XLEN = 32,
  parameter logic [XLEN-1:0] VEC_RESET = 32'h8000_0000
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            hold,
  input  logic [XLEN-1:0] next_addr,
  output logic [XLEN-1:0] pc_q,
  output logic [XLEN-1:0] pc4_q
);
  localparam logic [XLEN-1:0] WORD = XLEN'(4);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q  <= VEC_RESET;
      pc4_q <= VEC_RESET + WORD;
    end else if (!hold) begin
      pc_q  <= next_addr;
      pc4_q <= next_addr + WORD;
    end
  end
endmodule

// File: rtl/pc_steer.sv
module pc_steer
  import pcsteer_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int FIELD_W = 26,
  parameter int IMM_W   = 16,
  parameter logic [XLEN-1:0] VEC_RESET = 32'h8000_0000,
  parameter logic [XLEN-1:0] VEC_ILL   = 32'h8000_0040,
  parameter logic [XLEN-1:0] VEC_IRQ   = 32'h8000_0080
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               stall,
  input  logic [SEL_W-1:0]   sel,
  input  logic [FIELD_W-1:0] instr_field,
  input  logic [XLEN-1:0]    reg_jump,
  output logic [XLEN-1:0]    pc,
  output logic [XLEN-1:0]    pc_plus4
);
  pc_cand_t        cand;
  logic [XLEN-1:0] nxt;

  pcsteer_targets #(.XLEN(XLEN), .FIELD_W(FIELD_W), .IMM_W(IMM_W)) u_tgt (
    .cur_pc    (pc),
    .field     (instr_field),
    .rj_val    (reg_jump),
    .seq_addr  (cand.seq),
    .brch_addr (cand.brch),
    .jabs_addr (cand.jabs),
    .jreg_addr (cand.jreg)
  );

  pcsteer_mux #(.XLEN(XLEN), .VEC_RESET(VEC_RESET), .VEC_ILL(VEC_ILL),
                .VEC_IRQ(VEC_IRQ)) u_mux (
    .code      (sel),
    .seq_addr  (cand.seq),
    .brch_addr (cand.brch),
    .jabs_addr (cand.jabs),
    .jreg_addr (cand.jreg),
    .next_addr (nxt)
  );

  pcsteer_reg #(.XLEN(XLEN), .VEC_RESET(VEC_RESET)) u_reg (
    .clk       (clk),
    .rst       (rst),
    .hold      (stall),
    .next_addr (nxt),
    .pc_q      (pc),
    .pc4_q     (pc_plus4)
  );
endmodule

// File: rtl/pc_steer_chk.sv
module pc_steer_chk (
  input logic        clk,
  input logic        rst,
  input logic        stall,
  input logic [2:0]  sel,
  input logic [25:0] instr_field,
  input logic [31:0] reg_jump,
  input logic [31:0] pc,
  input logic [31:0] pc_plus4
);
  logic armed = 1'b0;
  always_ff @(posedge clk) if (rst) armed <= 1'b1;

  AST_RESET_LOAD: assert property (@(posedge clk)
    rst |=> (pc == 32'h8000_0000 && pc_plus4 == 32'h8000_0004)); // R1
  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
    (armed && !stall && (sel == 3'd0 || sel == 3'd7)) |=> pc == $past(pc) + 32'd4); // R2
  AST_BRANCH_TGT: assert property (@(posedge clk) disable iff (rst)
    (armed && !stall && sel == 3'd1) |=>
      pc == $past(pc) + 32'd4 + {{14{$past(instr_field[15])}}, $past(instr_field[15:0]), 2'b00}); // R3
  AST_JABS_TGT: assert property (@(posedge clk) disable iff (rst)
    (armed && !stall && sel == 3'd2) |=>
      (pc[31:28] == $past(pc[31:28]) && pc[27:2] == $past(instr_field))); // R4
  AST_JREG_TGT: assert property (@(posedge clk) disable iff (rst)
    (armed && !stall && sel == 3'd3) |=> pc[31:2] == $past(reg_jump[31:2])); // R5
  AST_ILL_VEC: assert property (@(posedge clk) disable iff (rst)
    (armed && !stall && sel == 3'd4) |=> pc == 32'h8000_0040); // R6
  AST_IRQ_VEC: assert property (@(posedge clk) disable iff (rst)
    (armed && !stall && sel == 3'd5) |=> pc == 32'h8000_0080); // R7
  AST_RST_VEC: assert property (@(posedge clk) disable iff (rst)
    (armed && !stall && sel == 3'd6) |=> pc == 32'h8000_0000); // R8
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (armed && stall) |=> ($stable(pc) && $stable(pc_plus4))); // R10
  AST_SUCC_PAIR: assert property (@(posedge clk) disable iff (rst)
    armed |-> pc_plus4 == pc + 32'd4); // R11
  AST_WORD_ALIGN: assert property (@(posedge clk) disable iff (rst)
    armed |-> pc[1:0] == 2'b00); // R13
endmodule

bind pc_steer pc_steer_chk u_chk (
  .clk(clk), .rst(rst), .stall(stall), .sel(sel), .instr_field(instr_field),
  .reg_jump(reg_jump), .pc(pc), .pc_plus4(pc_plus4)
);

// File: tb/tb_pc_steer.sv
module tb_pc_steer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        stall = 1'b0;
  logic [2:0]  sel = 3'd0;
  logic [25:0] instr_field = '0;
  logic [31:0] reg_jump = '0;
  logic [31:0] pc, pc_plus4;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pc_steer dut (
    .clk(clk), .rst(rst), .stall(stall), .sel(sel), .instr_field(instr_field),
    .reg_jump(reg_jump), .pc(pc), .pc_plus4(pc_plus4)
  );

  // entry: {sel, instr_field, reg_jump, expected pc after the edge}
  localparam int NV = 15;
  localparam logic [92:0] VEC [NV] = '{
    {3'd0, 26'h0000000, 32'h0000_0000, 32'h8000_0004},  // R2
    {3'd1, 26'h3CD0003, 32'h0000_0000, 32'h8000_0014},  // R3 +3 words
    {3'd1, 26'h000FFFE, 32'h0000_0000, 32'h8000_0010},  // R3 -2 words
    {3'd2, 26'h0000100, 32'hDEAD_BEEF, 32'h8000_0400},  // R4
    {3'd3, 26'h1555555, 32'h1234_5677, 32'h1234_5674},  // R5 misaligned
    {3'd0, 26'h0000000, 32'h0000_0000, 32'h1234_5678},  // R2
    {3'd2, 26'h3FFFFFF, 32'h0000_0000, 32'h1FFF_FFFC},  // R4 upper bits kept
    {3'd4, 26'h0ABCDEF, 32'h4444_4444, 32'h8000_0040},  // R6
    {3'd5, 26'h0ABCDEF, 32'h4444_4444, 32'h8000_0080},  // R7
    {3'd6, 26'h0ABCDEF, 32'h4444_4444, 32'h8000_0000},  // R8
    {3'd7, 26'h3FFFFFF, 32'hFFFF_FFFF, 32'h8000_0004},  // R9
    {3'd3, 26'h0000000, 32'hFFFF_FFFF, 32'hFFFF_FFFC},  // R5
    {3'd0, 26'h0000000, 32'h0000_0000, 32'h0000_0000},  // R12 wrap
    {3'd1, 26'h0008000, 32'h0000_0000, 32'hFFFE_0004},  // R12 most negative
    {3'd1, 26'h0007FFF, 32'h0000_0000, 32'h0000_0004}   // R12 carry dropped
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    // R1: reset with noise on every other input
    sel = 3'd1; stall = 1'b1; instr_field = 26'h3FFFFFF; reg_jump = 32'hFFFF_FFFF;
    step(); step();
    check("R1 pc", pc, 32'h8000_0000);
    check("R1 pc_plus4", pc_plus4, 32'h8000_0004);
    rst = 1'b0; stall = 1'b0;

    for (int i = 0; i < NV; i++) begin
      sel = VEC[i][92:90];
      instr_field = VEC[i][89:64];
      reg_jump = VEC[i][63:32];
      step();
      check($sformatf("R2-9/12 vec %0d pc", i), pc, VEC[i][31:0]);
      check($sformatf("R11 vec %0d pc_plus4", i), pc_plus4, VEC[i][31:0] + 32'd4);
      check($sformatf("R13 vec %0d align", i), {30'd0, pc[1:0]}, 32'd0);
    end

    // R10: stall holds the PC for two cycles against an active select
    sel = 3'd4; stall = 1'b1;
    step(); step();
    check("R10 hold pc", pc, 32'h0000_0004);
    check("R10 hold pc_plus4", pc_plus4, 32'h0000_0008);
    stall = 1'b0; sel = 3'd5;
    step();
    check("R7 after stall", pc, 32'h8000_0080);

    // R10: reset wins over stall
    stall = 1'b1; rst = 1'b1; sel = 3'd3; reg_jump = 32'h0000_1000;
    step();
    check("R10 reset over stall", pc, 32'h8000_0000);
    rst = 1'b0; stall = 1'b0; sel = 3'd0;
    step();
    check("R2 after reset", pc, 32'h8000_0004);
    check("R11 after reset", pc_plus4, 32'h8000_0008);
    finish_run();
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule